// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block sits between instruction decode and the ALU. It accepts a decoded mode code, a 16-bit address or constant field and a register selector. From these it works out the effective address of the operand and fetches the operand value. Depending on the mode it reads a small register file, adds a program-counter, index or base value to the field, and issues zero, one or two reads to a synchronous memory. For the pointer-walking modes it writes the adjusted pointer back into the register file.

A request is offered by raising `start` while the unit is idle. The unit then runs its sequence and raises `done` for a single cycle. In that cycle `ea`, `operand` and `err` carry the result, and they hold until the next result. Memory data is expected one cycle after a read is issued. The register file read is combinational.

Top module: `opnd_resolver`

## Requirements
- R1: After reset, done, busy, err, ea and operand are all low. done is a one-cycle pulse, and busy is high from the cycle after start is accepted until the cycle in which done is high.
- R2: With N memory reads for the mode, done goes high on the (N+1)th rising edge after the edge that accepts start, and N never exceeds 2.
- R3: Immediate (mode 0) gives operand = field and ea = 0, with no memory read.
- R4: Memory direct (mode 1) gives ea = field, with one read at field and operand = memory[field].
- R5: Memory indirect (mode 2) reads memory[field] to get ea, then reads memory[ea] for the operand, so two reads in all.
- R6: Register direct (mode 3) gives operand = R[reg_sel] and ea = 0, with no memory read.
- R7: Register indirect (mode 4) gives ea = R[reg_sel], with one read and operand = memory[ea].
- R8: Post-increment (mode 5) behaves as mode 4 and writes R[reg_sel]+1 (modulo 2^16) back once.
- R9: Pre-decrement (mode 6) uses ea = R[reg_sel]-1 (modulo 2^16), writes that value back once, and makes one read at ea.
- R10: Relative (mode 7), indexed (mode 8) and based (mode 9) use ea = pc_val, idx_val or base_val respectively plus field (modulo 2^16), with one read and operand = memory[ea].
- R11: Codes 10 to 15 raise err together with done, give ea = operand = 0, and make no memory read and no write-back. err is low for codes 0 to 9.
- R12: start is ignored while busy. No extra request is taken and no extra done is produced. While idle, neither mem_re nor rf_we is asserted.
- R13: Only modes 5 and 6 write the register file, and they do so in the same cycle as their single memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 4 | Addressing-mode code |
| field | input | 16 | Address or constant field of the instruction |
| reg_sel | input | 3 | Register selector for the register modes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Unsupported mode code, valid with done |
| ea | output | 16 | Effective address, valid with done |
| operand | output | 16 | Operand value, valid with done |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data, combinational |
| rf_we | output | 1 | Pointer write-back enable |
| rf_waddr | output | 3 | Pointer write-back index |
| rf_wdata | output | 16 | Updated pointer value |
| pc_val | input | 16 | Current program counter |
| idx_val | input | 16 | Index register value |
| base_val | input | 16 | Base register value |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory data, one cycle after mem_re |

## Verification
The result of a request falls due on a cycle set by how many reads its mode makes. For a mode with no read, done appears one edge after acceptance. One read adds an edge, and memory indirect adds a third. The bench sets start on a falling edge and counts falling edges until done. It requires that count to equal the read count plus two, and it compares ea, operand, err and the register file only in that cycle and after it. The memory model answers with a computed function of the address on the edge after mem_re. The number of reads and the number of write-backs are tallied per request against the count each mode should make.

// File: rtl/opres_pkg.sv
// Shared constants and types for the operand addressing-mode resolver.
// Assumes ten supported modes; the code width is derived from that count.
package opres_pkg;

    localparam int NUM_MODES = 10;
    localparam int MODE_W    = $clog2(NUM_MODES);

    localparam logic [MODE_W-1:0] MD_IMM   = MODE_W'(0);
    localparam logic [MODE_W-1:0] MD_MDIR  = MODE_W'(1);
    localparam logic [MODE_W-1:0] MD_MIND  = MODE_W'(2);
    localparam logic [MODE_W-1:0] MD_RDIR  = MODE_W'(3);
    localparam logic [MODE_W-1:0] MD_RIND  = MODE_W'(4);
    localparam logic [MODE_W-1:0] MD_PINC  = MODE_W'(5);
    localparam logic [MODE_W-1:0] MD_PDEC  = MODE_W'(6);
    localparam logic [MODE_W-1:0] MD_REL   = MODE_W'(7);
    localparam logic [MODE_W-1:0] MD_IDX   = MODE_W'(8);
    localparam logic [MODE_W-1:0] MD_BASE  = MODE_W'(9);

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_PTR,
        ST_FETCH
    } seq_state_e;

    // Per-mode behaviour flags
    typedef struct packed {
        logic legal;     // code names a supported mode
        logic imm;       // operand comes from the field
        logic reg_op;    // operand comes from the register file
        logic two_read;  // pointer read precedes the operand read
        logic wb;        // pointer write-back required
    } mode_info_t;

endpackage

// File: rtl/opres_mode_dec.sv
// Mode decoder: maps a mode code onto behaviour flags.
// Assumes codes at or above NUM_MODES are unsupported.
module opres_mode_dec
    import opres_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    output mode_info_t        info
);

    // Translate the code into flags
    always_comb begin
        info = '0;
        info.legal = 1'b1;
        unique case (mode_code)
            MD_IMM:  info.imm      = 1'b1;
            MD_RDIR: info.reg_op   = 1'b1;
            MD_MIND: info.two_read = 1'b1;
            MD_PINC, MD_PDEC: info.wb = 1'b1;
            MD_MDIR, MD_RIND, MD_REL, MD_IDX, MD_BASE: ;
            default: info.legal    = 1'b0;
        endcase
    end

endmodule

// File: rtl/opres_addr_gen.sv
// Address generator: forms the first access address and the updated
// pointer value from the latched request and the live register inputs.
// Assumes all arithmetic wraps modulo 2^DW.
module opres_addr_gen
    import opres_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [MODE_W-1:0] mode_code,
    input  logic [DW-1:0]     field_val,
    input  logic [DW-1:0]     reg_val,
    input  logic [DW-1:0]     pc_val,
    input  logic [DW-1:0]     idx_val,
    input  logic [DW-1:0]     base_val,
    output logic [DW-1:0]     addr,
    output logic [DW-1:0]     ptr_next
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] reg_dec;
    logic [DW-1:0] reg_inc;

    // Pointer adjust values shared by address and write-back
    always_comb begin
        reg_dec = reg_val - ONE;
        reg_inc = reg_val + ONE;
    end

    // Select the first access address per mode
    always_comb begin
        unique case (mode_code)
            MD_MDIR, MD_MIND: addr = field_val;
            MD_RIND, MD_PINC: addr = reg_val;
            MD_PDEC:          addr = reg_dec;
            MD_REL:           addr = pc_val + field_val;
            MD_IDX:           addr = idx_val + field_val;
            MD_BASE:          addr = base_val + field_val;
            default:          addr = '0;
        endcase
    end

    // Select the value written back to the pointer register
    always_comb begin
        ptr_next = (mode_code == MD_PINC) ? reg_inc : reg_dec;
    end

endmodule

// File: rtl/opres_ctrl.sv
// Sequencer: latches a request while idle, runs zero, one or two memory
// reads, and registers the result with a one-cycle done pulse.
// Assumes memory data arrives one cycle after the read strobe.
module opres_ctrl
    import opres_pkg::*;
#(
    parameter int DW  = 16,
    parameter int RAW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [DW-1:0]     field_in,
    input  logic [RAW-1:0]    sel_in,
    input  mode_info_t        info,
    input  logic [DW-1:0]     addr_calc,
    input  logic [DW-1:0]     reg_val,
    input  logic [DW-1:0]     mem_rdata,
    output logic [MODE_W-1:0] mode_q,
    output logic [DW-1:0]     field_q,
    output logic [RAW-1:0]    sel_q,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DW-1:0]     ea,
    output logic [DW-1:0]     operand,
    output logic              mem_re,
    output logic [DW-1:0]     mem_addr,
    output logic              wb_en
);

    seq_state_e state;
    logic       accept;
    logic       no_read;

    // Request acceptance and zero-read classification
    always_comb begin
        accept  = (state == ST_IDLE) && start;
        no_read = !info.legal || info.imm || info.reg_op;
    end

    // Latch the request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            field_q <= '0;
            sel_q   <= '0;
        end else if (accept) begin
            mode_q  <= mode_in;
            field_q <= field_in;
            sel_q   <= sel_in;
        end
    end

    // State sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start) state <= ST_EVAL;
                ST_EVAL:  begin
                    if (no_read)            state <= ST_IDLE;
                    else if (info.two_read) state <= ST_PTR;
                    else                    state <= ST_FETCH;
                end
                ST_PTR:   state <= ST_FETCH;
                ST_FETCH: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Result registers and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            err     <= 1'b0;
            ea      <= '0;
            operand <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_EVAL: begin
                    if (!info.legal) begin
                        done    <= 1'b1;
                        err     <= 1'b1;
                        ea      <= '0;
                        operand <= '0;
                    end else if (info.imm) begin
                        done    <= 1'b1;
                        err     <= 1'b0;
                        ea      <= '0;
                        operand <= field_q;
                    end else if (info.reg_op) begin
                        done    <= 1'b1;
                        err     <= 1'b0;
                        ea      <= '0;
                        operand <= reg_val;
                    end else begin
                        ea      <= addr_calc;
                    end
                end
                ST_PTR: ea <= mem_rdata;
                ST_FETCH: begin
                    done    <= 1'b1;
                    err     <= 1'b0;
                    operand <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Memory strobe, address and write-back enable
    always_comb begin
        busy     = (state != ST_IDLE);
        mem_re   = ((state == ST_EVAL) && !no_read) || (state == ST_PTR);
        mem_addr = (state == ST_PTR) ? mem_rdata : addr_calc;
        wb_en    = (state == ST_EVAL) && info.legal && info.wb;
    end

endmodule

// File: rtl/opnd_resolver.sv
// Top of the operand addressing-mode resolver: ties the sequencer, the
// mode decoder and the address generator to the block's ports.
// Assumes a combinational register-file read and single-cycle memory latency.
module opnd_resolver
    import opres_pkg::*;
#(
    parameter int DW  = 16,
    parameter int RAW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     field,
    input  logic [RAW-1:0]    reg_sel,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DW-1:0]     ea,
    output logic [DW-1:0]     operand,
    output logic [RAW-1:0]    rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [RAW-1:0]    rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    input  logic [DW-1:0]     pc_val,
    input  logic [DW-1:0]     idx_val,
    input  logic [DW-1:0]     base_val,
    output logic              mem_re,
    output logic [DW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata
);

    logic [MODE_W-1:0] mode_q;
    logic [DW-1:0]     field_q;
    logic [RAW-1:0]    sel_q;
    mode_info_t        info;
    logic [DW-1:0]     addr_calc;
    logic [DW-1:0]     ptr_next;

    opres_mode_dec u_dec (
        .mode_code (mode_q),
        .info      (info)
    );

    opres_addr_gen #(.DW(DW)) u_agen (
        .mode_code (mode_q),
        .field_val (field_q),
        .reg_val   (rf_rdata),
        .pc_val    (pc_val),
        .idx_val   (idx_val),
        .base_val  (base_val),
        .addr      (addr_calc),
        .ptr_next  (ptr_next)
    );

    opres_ctrl #(.DW(DW), .RAW(RAW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_in   (mode),
        .field_in  (field),
        .sel_in    (reg_sel),
        .info      (info),
        .addr_calc (addr_calc),
        .reg_val   (rf_rdata),
        .mem_rdata (mem_rdata),
        .mode_q    (mode_q),
        .field_q   (field_q),
        .sel_q     (sel_q),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .ea        (ea),
        .operand   (operand),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .wb_en     (rf_we)
    );

    // Register-file port wiring from the latched selector
    always_comb begin
        rf_raddr = sel_q;
        rf_waddr = sel_q;
        rf_wdata = ptr_next;
    end

endmodule

// File: rtl/opres_chk.sv
// Protocol checker for the resolver, attached by bind. It counts reads
// per request and checks handshake and access rules at the ports.
module opres_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic mem_re,
    input logic rf_we
);

    logic [2:0] rd_cnt;

    // Reads issued since the current request was accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_cnt <= '0;
        else if (start && !busy)     rd_cnt <= '0;
        else if (mem_re && rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_read_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_cnt <= 3'd2);

    assert_err_noread_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> rd_cnt == 3'd0);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !rf_we));

    assert_wb_with_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_re);

endmodule

bind opnd_resolver opres_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .mem_re (mem_re),
    .rf_we  (rf_we)
);

// File: tb/sim_opnd_resolver.sv
`timescale 1ns/1ps
module sim_opnd_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] field = '0;
    logic [2:0]  reg_sel = '0;
    logic        busy, done, err;
    logic [15:0] ea, operand;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic [15:0] pc_val = 16'h0200;
    logic [15:0] idx_val = 16'h0300;
    logic [15:0] base_val = 16'hFFF0;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;

    logic [15:0] rf [8];
    logic [15:0] exp_rf [8];
    int checks = 0;
    int fails = 0;
    int rd_total = 0;
    int wb_total = 0;
    int done_total = 0;

    always #10 clk = ~clk;

    opnd_resolver u0 (.*);

    // Memory content is a computed function of the address
    function automatic logic [15:0] fmem(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // Synchronous memory with one-cycle latency, register file and tallies
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= fmem(mem_addr);
            rd_total  <= rd_total + 1;
        end
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            wb_total     <= wb_total + 1;
        end
        if (done) done_total <= done_total + 1;
    end
    assign rf_rdata = rf[rf_raddr];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5: return "R8";
            4'd6: return "R9";
            4'd7, 4'd8, 4'd9: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Issue one request and check every result against the model
    task automatic do_op(input logic [3:0] m, input logic [15:0] f, input logic [2:0] s);
        logic [15:0] e_ea, e_op, r;
        int e_n, e_wb, cyc, rd0, wb0;
        bit e_err;
        string rq;
        rq = req_of(m);
        r = exp_rf[s];
        e_err = 1'b0; e_wb = 0; e_ea = 16'h0; e_op = 16'h0; e_n = 1;
        case (m)
            4'd0: begin e_n = 0; e_op = f; end
            4'd1: e_ea = f;
            4'd2: begin e_n = 2; e_ea = fmem(f); end
            4'd3: begin e_n = 0; e_op = r; end
            4'd4: e_ea = r;
            4'd5: begin e_ea = r; e_wb = 1; exp_rf[s] = r + 16'd1; end
            4'd6: begin e_ea = r - 16'd1; e_wb = 1; exp_rf[s] = r - 16'd1; end
            4'd7: e_ea = pc_val + f;
            4'd8: e_ea = idx_val + f;
            4'd9: e_ea = base_val + f;
            default: begin e_n = 0; e_err = 1'b1; end
        endcase
        if (e_n != 0) e_op = fmem(e_ea);
        rd0 = rd_total; wb0 = wb_total;
        @(negedge clk);
        start = 1'b1; mode = m; field = f; reg_sel = s;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == e_n + 2, "R2", {rq, " latency"}, 16'(cyc), 16'(e_n + 2));
        chk(ea == e_ea, rq, "ea", ea, e_ea);
        chk(operand == e_op, rq, "operand", operand, e_op);
        chk(err == e_err, "R11", {rq, " err"}, 16'(err), 16'(e_err));
        chk(rd_total - rd0 == e_n, rq, "read count", 16'(rd_total - rd0), 16'(e_n));
        chk(wb_total - wb0 == e_wb, "R13", {rq, " write-backs"}, 16'(wb_total - wb0), 16'(e_wb));
        for (int i = 0; i < 8; i++)
            chk(rf[i] == exp_rf[i], "R13", $sformatf("%s reg %0d", rq, i), rf[i], exp_rf[i]);
        @(negedge clk);
        chk(!done, "R1", "done pulse width", 16'(done), 16'h0);
    endtask

    // Vector table: {mode, field, reg_sel}
    localparam logic [22:0] VEC [15] = '{
        {4'd0, 16'h1234, 3'd0},
        {4'd1, 16'h0040, 3'd0},
        {4'd2, 16'h0077, 3'd0},
        {4'd3, 16'h0000, 3'd2},
        {4'd4, 16'h0000, 3'd3},
        {4'd5, 16'h0000, 3'd4},
        {4'd5, 16'h0000, 3'd4},
        {4'd6, 16'h0000, 3'd5},
        {4'd6, 16'h0000, 3'd6},
        {4'd5, 16'h0000, 3'd7},
        {4'd7, 16'h0005, 3'd1},
        {4'd8, 16'hFFFF, 3'd1},
        {4'd9, 16'h0020, 3'd1},
        {4'd11, 16'h0040, 3'd4},
        {4'd15, 16'h1111, 3'd5}
    };

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int d0;
        for (int i = 0; i < 8; i++) begin
            rf[i] = 16'h0111 * 16'(i) + 16'h0020;
            exp_rf[i] = rf[i];
        end
        rf[6] = 16'h0000; exp_rf[6] = 16'h0000;
        rf[7] = 16'hFFFF; exp_rf[7] = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !busy && !err, "R1", "flags after reset", {13'd0, done, busy, err}, 16'h0);
        chk(ea == 16'h0 && operand == 16'h0, "R1", "results after reset", ea | operand, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_re && !rf_we, "R12", "idle strobes", {14'd0, mem_re, rf_we}, 16'h0);

        for (int v = 0; v < 15; v++)
            do_op(VEC[v][22:19], VEC[v][18:3], VEC[v][2:0]);

        // R12: start held while busy is ignored
        d0 = done_total;
        @(negedge clk);
        start = 1'b1; mode = 4'd2; field = 16'h0077; reg_sel = 3'd0;
        @(negedge clk);
        chk(busy, "R1", "busy after accept", 16'(busy), 16'h1);
        mode = 4'd0; field = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done, "R12", "done of first request", 16'(done), 16'h1);
        chk(operand == fmem(fmem(16'h0077)), "R12", "operand of first request",
            operand, fmem(fmem(16'h0077)));
        repeat (4) @(negedge clk);
        chk(done_total - d0 == 1, "R12", "done count", 16'(done_total - d0), 16'h1);
        chk(!busy, "R12", "idle after request", 16'(busy), 16'h0);

        finish_run();
    end

endmodule